// File: doc/BRIEF.md
# Partitioned Packed Integer Adder with Vector Register File

This block pairs a small file of wide vector registers with one adder whose carry chain can be split into independent lanes. Each instruction names a destination register, which also supplies the first operand, and a second source register. The result always lands back in the destination register, so the instruction is destructive. A lane-width code sets the split: 8, 16, 32 or 64 bits. Each lane adds on its own and wraps at its own width.

Four operations are provided. A packed add works on every lane. A scalar add works on the lowest lane only and keeps the rest of the destination. Two half moves copy either the upper or the lower 64-bit half of the second source into the destination and leave the other half alone. An instruction is taken on a one-cycle valid pulse. Its result is written one clock later, together with a done pulse. A dependent instruction issued on the very next cycle receives the fresh result through forwarding, so it never stalls.

A preload port writes any register directly and a combinational read port shows any register. Together they let the surrounding logic set up operands and inspect results.

Top module: `simd_add_unit`

## Requirements
- R1: An asserted reset (rst_n low) clears all eight 128-bit registers to zero. After release, the read port shows zero for every index.
- R2: A preload pulse writes preload_data into register preload_idx at the clock edge. The read port shows the new value from then on.
- R3: Operation code 00 (packed add) adds every lane. Lane k of the result equals lane k of the destination plus lane k of the source, modulo 2^width. The lane-width code is 00 for 8-bit, 01 for 16-bit, 10 for 32-bit and 11 for 64-bit lanes.
- R4: No carry passes from one lane into the next. A carry does pass freely between the bytes inside one lane.
- R5: Operation code 01 (scalar add) adds only the lane that starts at bit 0. All bits above that lane keep the destination's previous value.
- R6: Operation code 10 (move high) copies source bits 127:64 into destination bits 127:64. Destination bits 63:0 are unchanged.
- R7: Operation code 11 (move low) copies source bits 63:0 into destination bits 63:0. Destination bits 127:64 are unchanged.
- R8: The result is written only into the destination register. The source register and every other register keep their values.
- R9: done is high in exactly the cycle after an accepted issue_valid and low otherwise. The result is visible on the read port after the following clock edge.
- R10: An instruction issued in the cycle right after another one still sees the earlier result when it reads that instruction's destination, either as its own destination or as its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | One-cycle pulse that accepts an instruction |
| issue_op | input | 2 | Operation: 00 packed add, 01 scalar add, 10 move high, 11 move low |
| issue_lw | input | 2 | Lane width: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| issue_dst | input | 3 | Destination register, also the first operand |
| issue_src | input | 3 | Second-operand register |
| preload_en | input | 1 | Direct register write strobe |
| preload_idx | input | 3 | Register written by preload |
| preload_data | input | 128 | Value written by preload |
| rd_idx | input | 3 | Register shown on rd_data |
| rd_data | output | 128 | Contents of register rd_idx |
| done | output | 1 | High in the cycle after an accepted instruction |

## Verification
The bench builds the unit with its default parameters: 128-bit registers, eight entries and an 8-bit lane unit. At these values all four lane widths exist side by side within one register, including two 64-bit lanes. Operands made of all ones plus one therefore show at once whether a carry escapes a lane. Those same operands show whether a carry within a wide lane is wrongly cut off at a narrower boundary. The half moves act on the real 64-bit halves of a full register. Having eight registers leaves room to check that unrelated registers stay untouched, and to chain dependent instructions through distinct registers.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int VEC_W  = 128;
  localparam int N_REGS = 8;
  localparam int UNIT_W = 8;

  typedef enum logic [1:0] {
    OP_PADD = 2'b00,
    OP_SADD = 2'b01,
    OP_MOVH = 2'b10,
    OP_MOVL = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    LW_8  = 2'b00,
    LW_16 = 2'b01,
    LW_32 = 2'b10,
    LW_64 = 2'b11
  } lw_e;
endpackage

// File: rtl/simd_rst_sync.sv
module simd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int VW = simd_pkg::VEC_W,
  parameter int UW = simd_pkg::UNIT_W
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  logic [1:0]    lw,
  output logic [VW-1:0] sum
);
  localparam int NU    = VW / UW;
  localparam int CNT_W = $clog2(NU) + 1;

  logic [CNT_W-1:0] units_per_lane;
  logic [NU:0]      carry;

  always_comb units_per_lane = CNT_W'(1) << lw;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < NU; i++) begin : g_unit
    logic          lane_start;
    logic          cin;
    logic [UW:0]   part;
    // a unit that opens a lane takes no carry from below
    assign lane_start = ((CNT_W'(i) & (units_per_lane - CNT_W'(1))) == '0);
    assign cin        = lane_start ? 1'b0 : carry[i];
    assign part       = {1'b0, a[i*UW +: UW]} + {1'b0, b[i*UW +: UW]} + {{UW{1'b0}}, cin};
    assign sum[i*UW +: UW] = part[UW-1:0];
    assign carry[i+1] = part[UW];
  end
endmodule

// File: rtl/simd_exec.sv
module simd_exec #(
  parameter int VW = simd_pkg::VEC_W,
  parameter int UW = simd_pkg::UNIT_W
) (
  input  logic [1:0]    op,
  input  logic [1:0]    lw,
  input  logic [VW-1:0] opa,
  input  logic [VW-1:0] opb,
  output logic [VW-1:0] res
);
  import simd_pkg::*;
  localparam int NU     = VW / UW;
  localparam int HALF_U = NU / 2;
  localparam int CNT_W  = $clog2(NU) + 1;

  logic [VW-1:0]    sum;
  logic [CNT_W-1:0] units_per_lane;

  simd_lane_adder #(.VW(VW), .UW(UW)) u_add (
    .a  (opa),
    .b  (opb),
    .lw (lw),
    .sum(sum)
  );

  always_comb units_per_lane = CNT_W'(1) << lw;

  for (genvar i = 0; i < NU; i++) begin : g_sel
    logic in_low_lane;
    logic upper_half;
    assign in_low_lane = (CNT_W'(i) < units_per_lane);
    assign upper_half  = (i >= HALF_U);
    always_comb begin
      res[i*UW +: UW] = opa[i*UW +: UW];
      unique case (op_e'(op))
        OP_PADD: res[i*UW +: UW] = sum[i*UW +: UW];
        OP_SADD: if (in_low_lane) res[i*UW +: UW] = sum[i*UW +: UW];
        OP_MOVH: if (upper_half)  res[i*UW +: UW] = opb[i*UW +: UW];
        OP_MOVL: if (!upper_half) res[i*UW +: UW] = opb[i*UW +: UW];
        default: res[i*UW +: UW] = opa[i*UW +: UW];
      endcase
    end
  end
endmodule

// File: rtl/simd_regfile.sv
module simd_regfile #(
  parameter int VW = simd_pkg::VEC_W,
  parameter int NR = simd_pkg::N_REGS,
  localparam int IW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [VW-1:0] wb_data,
  input  logic          pl_en,
  input  logic [IW-1:0] pl_idx,
  input  logic [VW-1:0] pl_data,
  input  logic [IW-1:0] ra_idx,
  output logic [VW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [VW-1:0] rb_data,
  input  logic [IW-1:0] rc_idx,
  output logic [VW-1:0] rc_data
);
  logic [VW-1:0] regs_q [NR];
  logic [VW-1:0] regs_d [NR];

  always_comb begin
    for (int r = 0; r < NR; r++) regs_d[r] = regs_q[r];
    if (pl_en) regs_d[pl_idx] = pl_data;
    if (wb_en) regs_d[wb_idx] = wb_data;   // writeback wins over preload
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int r = 0; r < NR; r++) regs_q[r] <= '0;
    end else begin
      for (int r = 0; r < NR; r++) regs_q[r] <= regs_d[r];
    end
  end

  assign ra_data = regs_q[ra_idx];
  assign rb_data = regs_q[rb_idx];
  assign rc_data = regs_q[rc_idx];

  // R8: a writeback lands in the named register
  a_r8_wb_lands: assert property (@(posedge clk) disable iff (!rst_ns)
    wb_en |=> regs_q[$past(wb_idx)] == $past(wb_data));

  // R2: a preload without a colliding writeback lands in the named register
  a_r2_preload_lands: assert property (@(posedge clk) disable iff (!rst_ns)
    (pl_en && !(wb_en && wb_idx == pl_idx)) |=> regs_q[$past(pl_idx)] == $past(pl_data));
endmodule

// File: rtl/simd_add_unit.sv
module simd_add_unit #(
  parameter int VW = simd_pkg::VEC_W,
  parameter int NR = simd_pkg::N_REGS,
  parameter int UW = simd_pkg::UNIT_W,
  localparam int IW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [1:0]    issue_op,
  input  logic [1:0]    issue_lw,
  input  logic [IW-1:0] issue_dst,
  input  logic [IW-1:0] issue_src,
  input  logic          preload_en,
  input  logic [IW-1:0] preload_idx,
  input  logic [VW-1:0] preload_data,
  input  logic [IW-1:0] rd_idx,
  output logic [VW-1:0] rd_data,
  output logic          done
);
  import simd_pkg::*;
  localparam int HALF = VW / 2;

  logic          rst_ns;
  logic [VW-1:0] rf_a, rf_b;
  logic [VW-1:0] opa, opb, res;
  logic          wb_vld_q, wb_vld_d;
  logic [IW-1:0] wb_idx_q, wb_idx_d;
  logic [VW-1:0] wb_dat_q, wb_dat_d;

  simd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  simd_regfile #(.VW(VW), .NR(NR)) u_rf (
    .clk    (clk),
    .rst_ns (rst_ns),
    .wb_en  (wb_vld_q),
    .wb_idx (wb_idx_q),
    .wb_data(wb_dat_q),
    .pl_en  (preload_en),
    .pl_idx (preload_idx),
    .pl_data(preload_data),
    .ra_idx (issue_dst),
    .ra_data(rf_a),
    .rb_idx (issue_src),
    .rb_data(rf_b),
    .rc_idx (rd_idx),
    .rc_data(rd_data)
  );

  // bypass the pending writeback to a back-to-back reader
  always_comb begin
    opa = (wb_vld_q && wb_idx_q == issue_dst) ? wb_dat_q : rf_a;
    opb = (wb_vld_q && wb_idx_q == issue_src) ? wb_dat_q : rf_b;
  end

  simd_exec #(.VW(VW), .UW(UW)) u_exec (
    .op (issue_op),
    .lw (issue_lw),
    .opa(opa),
    .opb(opb),
    .res(res)
  );

  always_comb begin
    wb_vld_d = issue_valid;
    wb_idx_d = wb_idx_q;
    wb_dat_d = wb_dat_q;
    if (issue_valid) begin
      wb_idx_d = issue_dst;
      wb_dat_d = res;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wb_vld_q <= 1'b0;
      wb_idx_q <= '0;
      wb_dat_q <= '0;
    end else begin
      wb_vld_q <= wb_vld_d;
      wb_idx_q <= wb_idx_d;
      wb_dat_q <= wb_dat_d;
    end
  end

  assign done = wb_vld_q;

  // R9: done follows exactly one cycle after an issue
  a_r9_done_after_issue: assert property (@(posedge clk) disable iff (!rst_ns)
    issue_valid |=> done);
  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_ns)
    !issue_valid |=> !done);

  // R3: a 64-bit packed lane matches a plain 64-bit add
  a_r3_lane64_add: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue_valid && issue_op == OP_PADD && issue_lw == LW_64)
      |-> res[HALF-1:0] == opa[HALF-1:0] + opb[HALF-1:0]);

  // R4: the lowest 8-bit lane matches a plain byte add in packed mode
  a_r4_lane8_add: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue_valid && issue_op == OP_PADD && issue_lw == LW_8)
      |-> res[UW-1:0] == opa[UW-1:0] + opb[UW-1:0]);

  // R5: scalar byte add leaves everything above the low lane alone
  a_r5_scalar_upper: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue_valid && issue_op == OP_SADD && issue_lw == LW_8)
      |-> res[VW-1:UW] == opa[VW-1:UW]);

  // R6: move high
  a_r6_movh: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue_valid && issue_op == OP_MOVH)
      |-> (res[HALF-1:0] == opa[HALF-1:0] && res[VW-1:HALF] == opb[VW-1:HALF]));

  // R7: move low
  a_r7_movl: assert property (@(posedge clk) disable iff (!rst_ns)
    (issue_valid && issue_op == OP_MOVL)
      |-> (res[VW-1:HALF] == opa[VW-1:HALF] && res[HALF-1:0] == opb[HALF-1:0]));
endmodule

// File: tb/tb_simd_add_unit.sv
module tb_simd_add_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [1:0]   op;
    logic [1:0]   lw;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] exp;
    logic [7:0]   req;
  } vec_t;

  // op 00 packed, 01 scalar, 10 move high, 11 move low; lw 00/01/10/11 = 8/16/32/64
  localparam vec_t VECS [NV] = '{
    // R3/R4 8-bit lanes wrap, no carry out
    '{2'b00, 2'b00, {16{8'hFF}}, {16{8'h01}}, 128'h0, 8'd4},
    '{2'b00, 2'b01, {8{16'hFFFF}}, {8{16'h0001}}, 128'h0, 8'd4},
    '{2'b00, 2'b10, {4{32'hFFFF_FFFF}}, {4{32'h1}}, 128'h0, 8'd4},
    '{2'b00, 2'b11, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, 128'h0, 8'd3},
    // R4 carry flows inside a 64-bit lane
    '{2'b00, 2'b11, {2{64'h0000_0000_FFFF_FFFF}}, {2{64'h1}}, {2{64'h0000_0001_0000_0000}}, 8'd4},
    // R4 same operands cut at 32-bit boundaries
    '{2'b00, 2'b10, {2{64'h0000_0000_FFFF_FFFF}}, {2{64'h1}}, 128'h0, 8'd4},
    // R3 plain packed byte add
    '{2'b00, 2'b00, {16{8'h7F}}, {16{8'h01}}, {16{8'h80}}, 8'd3},
    '{2'b00, 2'b01, {8{16'h8001}}, {8{16'h8001}}, {8{16'h0002}}, 8'd3},
    // R5 scalar adds
    '{2'b01, 2'b00, {16{8'hFF}}, {16{8'h02}}, {{15{8'hFF}}, 8'h01}, 8'd5},
    '{2'b01, 2'b10, {4{32'h8000_0000}}, {4{32'h8000_0000}}, {{3{32'h8000_0000}}, 32'h0}, 8'd5},
    '{2'b01, 2'b11, {2{64'h1}}, {2{64'h2}}, {64'h1, 64'h3}, 8'd5},
    // R6 move high, R7 move low
    '{2'b10, 2'b00, {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555},
      {64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444},
      {64'h1234_5678_9ABC_DEF0, 64'h5555_5555_5555_5555}, 8'd6},
    '{2'b11, 2'b00, {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555},
      {64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444},
      {64'hAAAA_AAAA_AAAA_AAAA, 64'h1111_2222_3333_4444}, 8'd7}
  };

  logic         clk;
  logic         rst_n;
  logic         issue_valid;
  logic [1:0]   issue_op;
  logic [1:0]   issue_lw;
  logic [2:0]   issue_dst;
  logic [2:0]   issue_src;
  logic         preload_en;
  logic [2:0]   preload_idx;
  logic [127:0] preload_data;
  logic [2:0]   rd_idx;
  logic [127:0] rd_data;
  logic         done;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  simd_add_unit dut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_op(issue_op), .issue_lw(issue_lw),
    .issue_dst(issue_dst), .issue_src(issue_src),
    .preload_en(preload_en), .preload_idx(preload_idx), .preload_data(preload_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [2:0] idx, input logic [127:0] data);
    preload_en = 1'b1; preload_idx = idx; preload_data = data;
    @(posedge clk); @(negedge clk);
    preload_en = 1'b0;
  endtask

  task automatic readreg(input logic [2:0] idx, output logic [127:0] val);
    rd_idx = idx;
    #1 val = rd_data;
  endtask

  task automatic drive_issue(input logic [1:0] op, input logic [1:0] lw,
                             input logic [2:0] dst, input logic [2:0] src);
    issue_valid = 1'b1; issue_op = op; issue_lw = lw; issue_dst = dst; issue_src = src;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [127:0] v;
    issue_valid = 0; issue_op = 0; issue_lw = 0; issue_dst = 0; issue_src = 0;
    preload_en = 0; preload_idx = 0; preload_data = 0; rd_idx = 0;
    do_reset();

    // R1: all registers zero after reset, done idle
    for (int r = 0; r < 8; r++) begin
      readreg(3'(r), v);
      chk("R1 reset value", v, 128'h0);
    end
    chk("R9 done idle after reset", {127'h0, done}, 128'h0);

    // R2: preload visible on read port
    preload(3'd0, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
    readreg(3'd0, v);
    chk("R2 preload", v, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);

    // table walk: r1 = dst/first operand, r2 = source
    for (int k = 0; k < NV; k++) begin
      preload(3'd1, VECS[k].a);
      preload(3'd2, VECS[k].b);
      drive_issue(VECS[k].op, VECS[k].lw, 3'd1, 3'd2);
      @(posedge clk); @(negedge clk);
      issue_valid = 1'b0;
      chk("R9 done after issue", {127'h0, done}, 128'h1);
      @(posedge clk); @(negedge clk);
      chk("R9 done single pulse", {127'h0, done}, 128'h0);
      readreg(3'd1, v);
      nchk++;
      if (v !== VECS[k].exp) begin
        nerr++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[k].req, k, v, VECS[k].exp);
      end
      readreg(3'd2, v);
      chk("R8 source unchanged", v, VECS[k].b);
      readreg(3'd0, v);
      chk("R8 other register unchanged", v, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
    end

    // R10: back-to-back on the same destination, then as a source
    preload(3'd3, {16{8'h01}});
    preload(3'd4, {16{8'h01}});
    preload(3'd5, {16{8'h10}});
    drive_issue(2'b00, 2'b00, 3'd3, 3'd4);
    @(posedge clk); @(negedge clk);
    drive_issue(2'b00, 2'b00, 3'd3, 3'd4);
    @(posedge clk); @(negedge clk);
    drive_issue(2'b00, 2'b00, 3'd5, 3'd3);
    @(posedge clk); @(negedge clk);
    issue_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    readreg(3'd3, v);
    chk("R10 dependent destination", v, {16{8'h03}});
    readreg(3'd5, v);
    chk("R10 dependent source", v, {16{8'h13}});

    // R1: reset mid-run clears preloaded content
    preload(3'd6, {4{32'hCAFE_F00D}});
    readreg(3'd6, v);
    chk("R2 preload before reset", v, {4{32'hCAFE_F00D}});
    do_reset();
    readreg(3'd6, v);
    chk("R1 reset clears register", v, 128'h0);
    readreg(3'd3, v);
    chk("R1 reset clears register", v, 128'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule